// File: doc/BRIEF.md
# Address-masked GPIO register block

An eight-pin general-purpose I/O peripheral that sits on a simple memory-mapped bus (address, write data, write strobe, read strobe, read data). Its single data register appears at every word of a 1 KiB window at the bottom of the address map. Address bits 9 down to 2 of each access into that window act as a per-pin mask, so software can set, clear or sample any subset of pins in one bus cycle with no read-modify-write sequence.

A direction register selects, per pin, whether the pin is driven from the output data latch or sampled as an input through a two-flop synchronizer. Eight read-only identification bytes allow driver software to confirm that the block is present. Pin outputs, output enables and raw pin inputs are ports of the block; pad cells live outside it.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset, pad_out, pad_oe and bus_rdata are all 0, so every pin is an input.
- R2: A write to an address below 0x400 updates each output data bit whose mask bit (address bit 2+i for pin i) is 1 to the written bit, and leaves every bit whose mask bit is 0 unchanged; pad_out shows the result after the write's clock edge.
- R3: A read at an address below 0x400 returns 0 in every bit whose mask bit (address bit 2+i for pin i) is 0.
- R4: The direction register sits at 0x400, reads back as written, and drives pad_oe directly; bit value 1 makes the pin an output, 0 an input.
- R5: In a masked data read, a pin whose direction bit is 1 returns its output data bit; a pin whose direction bit is 0 returns pad_in passed through two flops, so a pad_in change is seen only by a read whose strobe is sampled at the third rising edge after the change, or later.
- R6: Read-only identification bytes: 0xFE0=0x61, 0xFE4=0x10, 0xFE8=0x04, 0xFEC=0x00, 0xFF0=0x0D, 0xFF4=0xF0, 0xFF8=0x05, 0xFFC=0xB1.
- R7: Reads of any other offset (including 0x404 and 0x800) return 0; writes to those offsets or to the identification bytes change neither pad_out nor pad_oe.
- R8: bus_rdata is registered: it takes the read value at the edge that samples bus_re and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_re | input | 1 | Read strobe, one access per cycle |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Asynchronous pin inputs |
| pad_out | output | 8 | Pin output data |
| pad_oe | output | 8 | Pin output enables (1 = drive) |

## Verification
Writes become visible on pad_out or pad_oe at the same rising edge that samples the strobe, and a read's data appears on bus_rdata at the edge that samples bus_re, so the bench drives on falling edges and compares at the next falling edge. Pin-input changes are applied on a falling edge and three back-to-back reads are issued: the first two must still return the old synchronized value and the third the new one, which pins down the two-flop depth. The scoreboard queue holds one expected byte per read, pushed by the driver and popped by a monitor one half-cycle after the sampling edge.

// File: rtl/gpio_mask_port.sv
module gpio_mask_port #(
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        pad_in,
  output logic [7:0]        pad_out,
  output logic [7:0]        pad_oe
);
  localparam int PINS = 8;
  localparam logic [ADDR_W-1:0] DIR_OFS = ADDR_W'(12'h400);

  logic [PINS-1:0] out_q, dir_q, rd_q, rd_next;
  logic [PINS-1:0] sync_q [SYNC_STAGES];

  wire             in_win   = (bus_addr >> 10) == '0;
  wire [PINS-1:0]  amask    = bus_addr[9:2];
  wire [PINS-1:0]  pin_view = (dir_q & out_q) | (~dir_q & sync_q[SYNC_STAGES-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= pad_in;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
    end else if (bus_we) begin
      if (in_win)                out_q <= (out_q & ~amask) | (bus_wdata & amask);
      else if (bus_addr == DIR_OFS) dir_q <= bus_wdata;
    end
  end

  always_comb begin
    rd_next = '0;
    if (in_win) rd_next = pin_view & amask;
    else begin
      case (bus_addr)
        DIR_OFS:          rd_next = dir_q;
        ADDR_W'(12'hFE0): rd_next = 8'h61;
        ADDR_W'(12'hFE4): rd_next = 8'h10;
        ADDR_W'(12'hFE8): rd_next = 8'h04;
        ADDR_W'(12'hFEC): rd_next = 8'h00;
        ADDR_W'(12'hFF0): rd_next = 8'h0D;
        ADDR_W'(12'hFF4): rd_next = 8'hF0;
        ADDR_W'(12'hFF8): rd_next = 8'h05;
        ADDR_W'(12'hFFC): rd_next = 8'hB1;
        default:          rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (bus_re) rd_q <= rd_next;
  end

  assign bus_rdata = rd_q;
  assign pad_out   = out_q;
  assign pad_oe    = dir_q;

  a_r2_keep_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && in_win) |=> ((pad_out ^ $past(pad_out)) & ~$past(amask)) == '0);

  a_r2_take_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && in_win) |=> ((pad_out ^ $past(bus_wdata)) & $past(amask)) == '0);

  a_r3_masked_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && in_win) |=> (bus_rdata & ~$past(amask)) == '0);

  a_r4_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == DIR_OFS) |=> pad_oe == $past(bus_wdata));

  a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(pad_out) && $stable(pad_oe)));

  a_r6_id_first: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == ADDR_W'(12'hFF0)) |=> bus_rdata == 8'h0D);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));
endmodule

// File: tb/gpio_mask_port_bench.sv
module gpio_mask_port_bench;
  logic        clk = 0, rst_n = 0;
  logic [11:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0, pad_in = '0;
  logic        bus_we = 0, bus_re = 0;
  logic [7:0]  bus_rdata, pad_out, pad_oe;
  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  gpio_mask_port u_gpio_mask_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe));

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(logic [11:0] a, logic [7:0] e, string tag);
    bus_addr = a; bus_re = 1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_re = 0;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      if (bus_re && rst_n) begin
        @(negedge clk);
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    check("R1 pad_out", pad_out, 8'h00);
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 rdata", bus_rdata, 8'h00);
    rst_n = 1;
    @(negedge clk);

    rd(12'hFE0, 8'h61, "R6 id0"); rd(12'hFE4, 8'h10, "R6 id1");
    rd(12'hFE8, 8'h04, "R6 id2"); rd(12'hFEC, 8'h00, "R6 id3");
    rd(12'hFF0, 8'h0D, "R6 id4"); rd(12'hFF4, 8'hF0, "R6 id5");
    rd(12'hFF8, 8'h05, "R6 id6"); rd(12'hFFC, 8'hB1, "R6 id7");

    wr(12'h400, 8'h0F);
    check("R4 pad_oe", pad_oe, 8'h0F);
    rd(12'h400, 8'h0F, "R4 readback");

    wr(12'h3FC, 8'hA5);
    check("R2 full mask", pad_out, 8'hA5);
    wr(12'h004, 8'h00);
    check("R2 single bit clear", pad_out, 8'hA4);
    wr(12'h3C0, 8'h3C);
    check("R2 upper nibble", pad_out, 8'h34);

    pad_in = 8'h90;
    repeat (3) @(negedge clk);
    rd(12'h3FC, 8'h94, "R5 mixed dir");
    rd(12'h03C, 8'h04, "R3 low mask");
    rd(12'h000, 8'h00, "R3 zero mask");
    rd(12'h3C0, 8'h90, "R3 high mask");

    pad_in = 8'h50;
    rd(12'h3FC, 8'h94, "R5 sync edge1");
    rd(12'h3FC, 8'h94, "R5 sync edge2");
    rd(12'h3FC, 8'h54, "R5 sync edge3");

    wr(12'hFF0, 8'hFF);
    wr(12'h800, 8'hFF);
    wr(12'h404, 8'hFF);
    check("R7 pad_out kept", pad_out, 8'h34);
    check("R7 pad_oe kept", pad_oe, 8'h0F);
    rd(12'hFF0, 8'h0D, "R7 id unchanged");
    rd(12'h800, 8'h00, "R7 unmapped 800");
    rd(12'h404, 8'h00, "R7 unmapped 404");

    rd(12'hFFC, 8'hB1, "R8 read");
    repeat (3) @(negedge clk);
    check("R8 hold", bus_rdata, 8'hB1);

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule